// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block gathers 32 interrupt sources into two processor-facing request lines: a normal request and a fast request. Each source has an enable bit and a routing bit that steers an enabled request to one line or the other. Software can raise any source itself through a soft-pending bit. That bit is ORed with the hardware line of the same source. Enable bits and soft bits each have one register that sets bits and another that clears them, so software can change a single bit without a read-modify-write.

Sixteen vector slots bind chosen sources to handler addresses. Slot 0 has the highest priority. A default handler address covers normal requests that no enabled slot owns. The handler reads the current-vector register to learn where to jump. That read also claims the request: its priority level is pushed onto an in-service stack. While a level is in service, only strictly higher-priority slots can produce a new claimable vector. Any write to the current-vector register ends service of the most recently claimed level. A protection register, a test control register and four read-only identification byte registers complete the register set.

All registers sit on a single-cycle 32-bit bus with word-aligned offsets. Read data is combinational from the current state. A read side effect (a claim) and all writes take effect at the clock edge that ends the bus cycle. Reset is synchronous and active-high.

Top module: `irqv_top`

## Requirements
- R1: After reset the enable, soft, routing, slot control, slot address, default address and protection registers are all zero, the in-service stack is empty, and both `irq_o` and `fiq_o` are low.
- R2: A write to offset 0x010 sets the enable bits written as 1. A write to offset 0x014 clears the enable bits written as 1. Zero bits change nothing in either register. A read of 0x010 returns the current enable mask.
- R3: A write to 0x018 sets soft-pending bits written as 1, and a write to 0x01C clears them. A read of 0x018 returns the soft bits. The raw request of a source, readable at 0x008, is its hardware line OR its soft bit.
- R4: The normal status at 0x000 equals raw AND enable AND NOT route, where route is the register at 0x00C (bit n = 1 steers source n to the fast line). `irq_o` is high exactly while this value is nonzero.
- R5: The fast status at 0x004 equals raw AND enable AND route. `fiq_o` is high exactly while this value is nonzero.
- R6: Slot n has an address register at 0x100+4n and a control register at 0x200+4n, with bit 5 as the slot enable and bits [4:0] as the source index. A read of the current vector at 0x030 returns the address of the lowest-numbered enabled slot whose source has a nonzero normal status.
- R7: When no slot qualifies and some pending normal source is owned by no enabled slot, a read of 0x030 returns the default address (register 0x034) and claims the default level. The default level ranks below every slot. A qualifying slot always wins over the default.
- R8: A read of 0x030 that returns a claimable vector pushes its level onto the in-service stack. While a level is in service, only slots with a strictly lower index are claimable. Otherwise the read returns the default address and claims nothing.
- R9: Any write to 0x030 removes the highest-priority level from the in-service stack, so the previously claimed lower level again limits which slots can be claimed.
- R10: The protection register (0x020, bit 0) and the test control register (0x024, bit 0) read back what was written. Both reset to 0.
- R11: The identification registers at 0xFE0, 0xFE4, 0xFE8 and 0xFEC return byte 0 to byte 3 of the cell id in bits [7:0], with the upper bits zero. The assembled id carries the vendor code in bits [19:12].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | 32 | Hardware interrupt lines, level sensitive |
| bus_en_i | input | 1 | Bus cycle valid |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 12 | Byte offset in the 4 KB window |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid during a read cycle |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
On every cycle, the assertions check four things. A cleared enable bit is really clear after the write. The test register is zero when reset ends. A level pushed onto the in-service stack always ranks above the current top. Each end-of-service write removes exactly one level. Also on every cycle, any slot vector the priority logic offers must belong to a slot whose source is pending and which outranks the in-service level. The scenarios alone show the register encodings, the slot-over-default ordering, and the effect of nested claims and pops on the vector a handler reads. They also show the routing split between the two outputs and the identification bytes.

// File: rtl/irqv_pkg.sv
package irqv_pkg;

    localparam int NUM_SRC    = 32;
    localparam int NUM_SLOT   = 16;
    localparam int SRC_IDX_W  = $clog2(NUM_SRC);
    localparam int SLOT_IDX_W = $clog2(NUM_SLOT);
    localparam int LVL_W      = $clog2(NUM_SLOT + 2);
    localparam int DATA_W     = 32;
    localparam int ADDR_W     = 12;

    // level NUM_SLOT is the default vector, NUM_SLOT+1 means nothing in service
    localparam logic [LVL_W-1:0] DEF_LVL  = LVL_W'(NUM_SLOT);
    localparam logic [LVL_W-1:0] IDLE_LVL = LVL_W'(NUM_SLOT + 1);

    typedef struct packed {
        logic                 en;
        logic [SRC_IDX_W-1:0] src;
    } slot_ctl_t;

    typedef enum logic [3:0] {
        REG_NONE,
        REG_IRQ_STAT,
        REG_FIQ_STAT,
        REG_RAW,
        REG_ROUTE,
        REG_EN_SET,
        REG_EN_CLR,
        REG_SOFT_SET,
        REG_SOFT_CLR,
        REG_PROT,
        REG_TEST,
        REG_CUR_VEC,
        REG_DEF_VEC,
        REG_SLOT_ADDR,
        REG_SLOT_CTL,
        REG_ID
    } reg_e;

    function automatic reg_e decode_reg(input logic [ADDR_W-1:0] a);
        if (a[1:0] != 2'b00)       return REG_NONE;
        if (a[11:6] == 6'h04)      return REG_SLOT_ADDR;
        if (a[11:6] == 6'h08)      return REG_SLOT_CTL;
        if (a[11:4] == 8'hFE)      return REG_ID;
        case (a)
            12'h000: return REG_IRQ_STAT;
            12'h004: return REG_FIQ_STAT;
            12'h008: return REG_RAW;
            12'h00C: return REG_ROUTE;
            12'h010: return REG_EN_SET;
            12'h014: return REG_EN_CLR;
            12'h018: return REG_SOFT_SET;
            12'h01C: return REG_SOFT_CLR;
            12'h020: return REG_PROT;
            12'h024: return REG_TEST;
            12'h030: return REG_CUR_VEC;
            12'h034: return REG_DEF_VEC;
            default: return REG_NONE;
        endcase
    endfunction

endpackage

// File: rtl/irqv_regs.sv
module irqv_regs
    import irqv_pkg::*;
#(
    parameter int          N_SRC   = NUM_SRC,
    parameter int          N_SLOT  = NUM_SLOT,
    parameter int          DW      = DATA_W,
    parameter int          AW      = ADDR_W,
    parameter logic [31:0] CELL_ID = 32'h0035_C0DE
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [N_SRC-1:0]          src_i,
    input  logic                      bus_en_i,
    input  logic                      bus_we_i,
    input  logic [AW-1:0]             bus_addr_i,
    input  logic [DW-1:0]             bus_wdata_i,
    output logic [DW-1:0]             bus_rdata_o,
    input  logic [DW-1:0]             vec_addr_i,
    output logic                      claim_o,
    output logic                      eoi_o,
    output logic [N_SRC-1:0]          irq_stat_o,
    output logic [N_SRC-1:0]          fiq_stat_o,
    output slot_ctl_t [N_SLOT-1:0]    slot_ctl_o,
    output logic [N_SLOT-1:0][DW-1:0] slot_addr_o,
    output logic [DW-1:0]             def_addr_o
);

    localparam int SIW = $clog2(N_SLOT);

    logic [N_SRC-1:0] en_q, soft_q, route_q, raw;
    logic             prot_q, test_q;
    reg_e             rsel;
    logic [SIW-1:0]   slot_idx;
    logic [1:0]       id_idx;
    logic             wr_cyc, rd_cyc;

    assign rsel     = decode_reg(bus_addr_i);
    assign slot_idx = bus_addr_i[SIW+1:2];
    assign id_idx   = bus_addr_i[3:2];
    assign wr_cyc   = bus_en_i && bus_we_i;
    assign rd_cyc   = bus_en_i && !bus_we_i;

    assign claim_o = rd_cyc && (rsel == REG_CUR_VEC);
    assign eoi_o   = wr_cyc && (rsel == REG_CUR_VEC);

    assign raw        = src_i | soft_q;
    assign irq_stat_o = raw & en_q & ~route_q;
    assign fiq_stat_o = raw & en_q & route_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q        <= '0;
            soft_q      <= '0;
            route_q     <= '0;
            prot_q      <= 1'b0;
            test_q      <= 1'b0;
            def_addr_o  <= '0;
            slot_ctl_o  <= '0;
            slot_addr_o <= '0;
        end else if (wr_cyc) begin
            case (rsel)
                REG_EN_SET:    en_q    <= en_q | bus_wdata_i[N_SRC-1:0];
                REG_EN_CLR:    en_q    <= en_q & ~bus_wdata_i[N_SRC-1:0];
                REG_SOFT_SET:  soft_q  <= soft_q | bus_wdata_i[N_SRC-1:0];
                REG_SOFT_CLR:  soft_q  <= soft_q & ~bus_wdata_i[N_SRC-1:0];
                REG_ROUTE:     route_q <= bus_wdata_i[N_SRC-1:0];
                REG_PROT:      prot_q  <= bus_wdata_i[0];
                REG_TEST:      test_q  <= bus_wdata_i[0];
                REG_DEF_VEC:   def_addr_o <= bus_wdata_i;
                REG_SLOT_ADDR: slot_addr_o[slot_idx] <= bus_wdata_i;
                REG_SLOT_CTL:  slot_ctl_o[slot_idx] <=
                                   slot_ctl_t'(bus_wdata_i[$bits(slot_ctl_t)-1:0]);
                default: ;
            endcase
        end
    end

    always_comb begin
        bus_rdata_o = '0;
        if (rd_cyc) begin
            case (rsel)
                REG_IRQ_STAT:  bus_rdata_o = DW'(irq_stat_o);
                REG_FIQ_STAT:  bus_rdata_o = DW'(fiq_stat_o);
                REG_RAW:       bus_rdata_o = DW'(raw);
                REG_ROUTE:     bus_rdata_o = DW'(route_q);
                REG_EN_SET:    bus_rdata_o = DW'(en_q);
                REG_SOFT_SET:  bus_rdata_o = DW'(soft_q);
                REG_PROT:      bus_rdata_o = DW'(prot_q);
                REG_TEST:      bus_rdata_o = DW'(test_q);
                REG_CUR_VEC:   bus_rdata_o = vec_addr_i;
                REG_DEF_VEC:   bus_rdata_o = def_addr_o;
                REG_SLOT_ADDR: bus_rdata_o = slot_addr_o[slot_idx];
                REG_SLOT_CTL:  bus_rdata_o = DW'(slot_ctl_o[slot_idx]);
                REG_ID:        bus_rdata_o = DW'(CELL_ID[8*id_idx +: 8]);
                default:       bus_rdata_o = '0;
            endcase
        end
    end

    // R2: enable bits written as 1 to the clear register are gone next cycle
    assert_en_clear_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_cyc && rsel == REG_EN_CLR) |=> ((en_q & $past(bus_wdata_i[N_SRC-1:0])) == '0));

    // R10: test control is zero once reset is released
    assert_test_reset_R10: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (test_q == 1'b0));

endmodule

// File: rtl/irqv_prio.sv
module irqv_prio
    import irqv_pkg::*;
#(
    parameter int N_SRC  = NUM_SRC,
    parameter int N_SLOT = NUM_SLOT,
    parameter int DW     = DATA_W,
    parameter int LW     = LVL_W
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [N_SRC-1:0]          irq_stat_i,
    input  slot_ctl_t [N_SLOT-1:0]    slot_ctl_i,
    input  logic [N_SLOT-1:0][DW-1:0] slot_addr_i,
    input  logic [DW-1:0]             def_addr_i,
    input  logic [LW-1:0]             top_lvl_i,
    output logic                      vec_valid_o,
    output logic [LW-1:0]             vec_lvl_o,
    output logic [DW-1:0]             vec_addr_o
);

    localparam int SIW = $clog2(N_SLOT);
    localparam logic [LW-1:0] L_DEF  = LW'(N_SLOT);
    localparam logic [LW-1:0] L_IDLE = LW'(N_SLOT + 1);

    logic [N_SLOT-1:0] slot_hit;
    logic [N_SRC-1:0]  covered;
    logic              default_req;

    for (genvar g = 0; g < N_SLOT; g++) begin : g_slot
        assign slot_hit[g] = slot_ctl_i[g].en && irq_stat_i[slot_ctl_i[g].src];
    end

    always_comb begin
        covered = '0;
        for (int i = 0; i < N_SLOT; i++) begin
            if (slot_ctl_i[i].en) covered[slot_ctl_i[i].src] = 1'b1;
        end
    end

    assign default_req = |(irq_stat_i & ~covered);

    always_comb begin
        vec_valid_o = 1'b0;
        vec_lvl_o   = L_IDLE;
        vec_addr_o  = def_addr_i;
        for (int i = N_SLOT - 1; i >= 0; i--) begin
            if (slot_hit[i] && (LW'(i) < top_lvl_i)) begin
                vec_valid_o = 1'b1;
                vec_lvl_o   = LW'(i);
                vec_addr_o  = slot_addr_i[i];
            end
        end
        if (!vec_valid_o && default_req && (top_lvl_i == L_IDLE)) begin
            vec_valid_o = 1'b1;
            vec_lvl_o   = L_DEF;
        end
    end

    // R6 / R8: an offered slot vector has a pending source and outranks the stack top
    assert_slot_vec_R6: assert property (@(posedge clk) disable iff (rst)
        (vec_valid_o && vec_lvl_o < L_DEF) |->
            (slot_hit[vec_lvl_o[SIW-1:0]] && vec_lvl_o < top_lvl_i));

endmodule

// File: rtl/irqv_stack.sv
module irqv_stack
    import irqv_pkg::*;
#(
    parameter int N_SLOT = NUM_SLOT,
    parameter int LW     = LVL_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push_i,
    input  logic [LW-1:0] push_lvl_i,
    input  logic          pop_i,
    output logic [LW-1:0] top_lvl_o
);

    localparam int NLVL = N_SLOT + 1;
    localparam logic [LW-1:0] L_IDLE = LW'(N_SLOT + 1);

    logic [NLVL-1:0] in_svc_q;
    logic [NLVL-1:0] top_mask;

    always_comb begin
        top_lvl_o = L_IDLE;
        top_mask  = '0;
        for (int i = NLVL - 1; i >= 0; i--) begin
            if (in_svc_q[i]) begin
                top_lvl_o = LW'(i);
                top_mask  = NLVL'(1) << i;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            in_svc_q <= '0;
        end else if (push_i) begin
            in_svc_q <= in_svc_q | (NLVL'(1) << push_lvl_i);
        end else if (pop_i) begin
            in_svc_q <= in_svc_q & ~top_mask;
        end
    end

    // R8: a claimed level always ranks above the current top
    assert_push_higher_R8: assert property (@(posedge clk) disable iff (rst)
        push_i |-> (push_lvl_i < top_lvl_o));

    // R9: an end-of-service write removes exactly one level
    assert_pop_one_R9: assert property (@(posedge clk) disable iff (rst)
        (pop_i && !push_i && (|in_svc_q)) |=>
            ($countones(in_svc_q) == $countones($past(in_svc_q)) - 1));

endmodule

// File: rtl/irqv_top.sv
module irqv_top
    import irqv_pkg::*;
#(
    parameter logic [31:0] CELL_ID = 32'h0035_C0DE
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_SRC-1:0]  src_i,
    input  logic                bus_en_i,
    input  logic                bus_we_i,
    input  logic [ADDR_W-1:0]   bus_addr_i,
    input  logic [DATA_W-1:0]   bus_wdata_i,
    output logic [DATA_W-1:0]   bus_rdata_o,
    output logic                irq_o,
    output logic                fiq_o
);

    logic [NUM_SRC-1:0]             irq_stat, fiq_stat;
    slot_ctl_t [NUM_SLOT-1:0]       slot_ctl;
    logic [NUM_SLOT-1:0][DATA_W-1:0] slot_addr;
    logic [DATA_W-1:0]              def_addr, vec_addr;
    logic                           claim, eoi, vec_valid;
    logic [LVL_W-1:0]               vec_lvl, top_lvl;

    irqv_regs #(.CELL_ID(CELL_ID)) u_regs (
        .clk         (clk),
        .rst         (rst),
        .src_i       (src_i),
        .bus_en_i    (bus_en_i),
        .bus_we_i    (bus_we_i),
        .bus_addr_i  (bus_addr_i),
        .bus_wdata_i (bus_wdata_i),
        .bus_rdata_o (bus_rdata_o),
        .vec_addr_i  (vec_addr),
        .claim_o     (claim),
        .eoi_o       (eoi),
        .irq_stat_o  (irq_stat),
        .fiq_stat_o  (fiq_stat),
        .slot_ctl_o  (slot_ctl),
        .slot_addr_o (slot_addr),
        .def_addr_o  (def_addr)
    );

    irqv_prio u_prio (
        .clk         (clk),
        .rst         (rst),
        .irq_stat_i  (irq_stat),
        .slot_ctl_i  (slot_ctl),
        .slot_addr_i (slot_addr),
        .def_addr_i  (def_addr),
        .top_lvl_i   (top_lvl),
        .vec_valid_o (vec_valid),
        .vec_lvl_o   (vec_lvl),
        .vec_addr_o  (vec_addr)
    );

    irqv_stack u_stack (
        .clk        (clk),
        .rst        (rst),
        .push_i     (claim && vec_valid),
        .push_lvl_i (vec_lvl),
        .pop_i      (eoi),
        .top_lvl_o  (top_lvl)
    );

    assign irq_o = |irq_stat;
    assign fiq_o = |fiq_stat;

endmodule

// File: tb/irqv_top_tb.sv
`timescale 1ns/1ps
module irqv_top_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] src = '0;
    logic        bus_en = 1'b0, bus_we = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o, fiq_o;

    int checks = 0;
    int errors = 0;
    localparam logic [31:0] ID_EXP = 32'h0035_C0DE;

    always #2.5 clk = ~clk;

    irqv_top #(.CELL_ID(ID_EXP)) dut_i (
        .clk(clk), .rst(rst), .src_i(src),
        .bus_en_i(bus_en), .bus_we_i(bus_we), .bus_addr_i(bus_addr),
        .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
        .irq_o(irq_o), .fiq_o(fiq_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_en = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [11:0] a, input logic [31:0] exp);
        logic [31:0] d;
        rd(a, d);
        check(req, d, exp);
    endtask

    task automatic t_reset;
        rd_chk("R1 enable", 12'h010, 32'h0);
        rd_chk("R1 soft", 12'h018, 32'h0);
        rd_chk("R1 route", 12'h00C, 32'h0);
        rd_chk("R1 slot ctl", 12'h204, 32'h0);
        rd_chk("R1 default addr", 12'h034, 32'h0);
        rd_chk("R10 test reset", 12'h024, 32'h0);
        rd_chk("R10 prot reset", 12'h020, 32'h0);
        check("R1 irq_o", {31'b0, irq_o}, 32'h0);
        check("R1 fiq_o", {31'b0, fiq_o}, 32'h0);
    endtask

    task automatic t_enable;
        wr(12'h010, 32'h0000_00F0);
        wr(12'h010, 32'h0000_0001);
        rd_chk("R2 set accumulates", 12'h010, 32'h0000_00F1);
        wr(12'h014, 32'h0000_0030);
        rd_chk("R2 clear", 12'h010, 32'h0000_00C1);
        wr(12'h010, 32'h0);
        wr(12'h014, 32'h0);
        rd_chk("R2 zero bits ignored", 12'h010, 32'h0000_00C1);
    endtask

    task automatic t_soft;
        wr(12'h018, 32'h0000_0040);
        rd_chk("R3 soft readback", 12'h018, 32'h0000_0040);
        rd_chk("R3 raw soft", 12'h008, 32'h0000_0040);
        rd_chk("R4 status soft", 12'h000, 32'h0000_0040);
        check("R4 irq_o soft", {31'b0, irq_o}, 32'h1);
        wr(12'h01C, 32'h0000_0040);
        rd_chk("R3 soft cleared", 12'h000, 32'h0);
        check("R4 irq_o low", {31'b0, irq_o}, 32'h0);
        src = 32'h0000_0101;
        rd_chk("R3 raw hw", 12'h008, 32'h0000_0101);
        rd_chk("R4 status masked", 12'h000, 32'h0000_0001);
    endtask

    task automatic t_route;
        wr(12'h00C, 32'h0000_0001);
        #1;
        check("R5 fiq_o", {31'b0, fiq_o}, 32'h1);
        check("R4 irq_o routed away", {31'b0, irq_o}, 32'h0);
        rd_chk("R5 fast status", 12'h004, 32'h0000_0001);
        rd_chk("R4 normal status", 12'h000, 32'h0);
        wr(12'h00C, 32'h0);
        src = '0;
        wr(12'h014, 32'hFFFF_FFFF);
        #1;
        check("R5 fiq_o low", {31'b0, fiq_o}, 32'h0);
    endtask

    task automatic t_vector;
        wr(12'h034, 32'h0000_0DEF);
        wr(12'h108, 32'h0000_0700);
        wr(12'h208, 32'h0000_0027);   // slot 2: enable, source 7
        wr(12'h114, 32'h0000_0300);
        wr(12'h214, 32'h0000_0023);   // slot 5: enable, source 3
        wr(12'h100, 32'h0000_0900);
        wr(12'h010, 32'h0000_0298);   // enable 3,4,7,9
        src = 32'h0000_0088;
        rd_chk("R6 highest slot wins", 12'h030, 32'h0000_0700);
        rd_chk("R8 lower slot blocked", 12'h030, 32'h0000_0DEF);
        wr(12'h200, 32'h0000_0029);   // slot 0: enable, source 9
        src = 32'h0000_0288;
        rd_chk("R8 higher slot nests", 12'h030, 32'h0000_0900);
        wr(12'h030, 32'h0);
        src = 32'h0000_0088;
        rd_chk("R9 pop keeps outer level", 12'h030, 32'h0000_0DEF);
        wr(12'h030, 32'h0);
        rd_chk("R9 empty stack reclaims", 12'h030, 32'h0000_0700);
        wr(12'h030, 32'h0);
        src = 32'h0000_0008;
        rd_chk("R6 next slot", 12'h030, 32'h0000_0300);
        wr(12'h030, 32'h0);
        src = '0;
        rd_chk("R7 nothing pending", 12'h030, 32'h0000_0DEF);
    endtask

    task automatic t_default;
        src = 32'h0000_0010;
        rd_chk("R7 default claim", 12'h030, 32'h0000_0DEF);
        src = 32'h0000_0018;
        rd_chk("R7 slot above default", 12'h030, 32'h0000_0300);
        wr(12'h030, 32'h0);
        wr(12'h030, 32'h0);
        rd_chk("R7 slot before default", 12'h030, 32'h0000_0300);
        wr(12'h030, 32'h0);
        src = '0;
    endtask

    task automatic t_misc;
        logic [31:0] id;
        logic [31:0] d;
        wr(12'h020, 32'h1);
        wr(12'h024, 32'h1);
        rd_chk("R10 prot readback", 12'h020, 32'h1);
        rd_chk("R10 test readback", 12'h024, 32'h1);
        id = '0;
        for (int i = 0; i < 4; i++) begin
            rd(12'hFE0 + 12'(4 * i), d);
            check("R11 id upper zero", {d[31:8], 8'h00}, 32'h0);
            id[8*i +: 8] = d[7:0];
        end
        check("R11 id assembled", id, ID_EXP);
        check("R11 vendor", {24'b0, id[19:12]}, 32'h0000_005C);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_enable();
        t_soft();
        t_route();
        t_vector();
        t_default();
        t_misc();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(5.0 * 100000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule